// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This block holds a set of programmable alarm bytes and compares them with the current calendar time, which arrives in packed BCD on five input buses. The time-keeping logic issues a `tick` strobe when a new second begins. On that strobe the comparator checks every alarm field against the matching time field. If all of them agree, it raises `alarm_hit` for exactly one clock. The comparator only handles 24-hour BCD time. Interrupt flags, masking and time keeping belong to the surrounding logic.

The alarm bytes are written through a small strobe interface: `reg_wr` with `reg_addr` and `reg_wdata`. Any byte can be read back at once on `reg_rdata` for the address currently on `reg_addr`. Any field can be turned into a wildcard.

The seconds, minutes and hours fields are always present. A day-of-month field and a month field are optional and chosen by parameters. They extend the alarm's reach:
- seconds, minutes and hours alone: the alarm repeats every day;
- adding the day field: it repeats every month;
- adding both day and month: it repeats every year.

A month field without a day field is not supported, and the month field is left out in that case.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, the alarm bytes read 0x00 (seconds), 0x00 (minutes), 0x00 (hours), 0x00 (day) and 0xFF (month), and `alarm_hit` is 0.
- R2: The register addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month. A write happens on the clock edge where `reg_wr` is 1. `reg_rdata` shows the byte at `reg_addr` combinationally. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R3: The day byte reads back as its low six bits with bits 7:6 forced to 0.
- R4: `alarm_hit` is 1 for exactly one cycle: the cycle after the first clock edge at which `tick` is sampled 1 after having been 0, and only if every field matches. At all other times it is 0.
- R5: A seconds, minutes or hours field matches when its alarm byte equals the current byte, or when alarm bits 7:6 are both 1 (wildcard, any value such as 0xC0 or 0xFF).
- R6: The day field is a wildcard when bits 7:6 are both 1 or bits 5:0 are all 0. Otherwise it matches when `now_day` equals {2'b00, alarm[5:0]}.
- R7: The month field is a wildcard when bits 7:6 are both 1. Otherwise it matches only on an exact byte match with `now_mon`.
- R8: If `tick` stays high for several cycles, only one comparison is made, on its first cycle.
- R9: With `HAS_DAY` = 0 the day and month registers are both absent. They read 0x00, ignore writes and always match. The month register exists only when both `HAS_DAY` and `HAS_MONTH` are 1.
- R10: When an alarm write and a new `tick` arrive on the same edge, the comparison uses the alarm value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for alarm bytes |
| reg_addr | input | 3 | Alarm byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the addressed alarm byte |
| tick | input | 1 | New-second strobe from the time keeper |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD, 24-hour form |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The bound checker watches these properties on every cycle:
- a pulse only follows a fresh tick and is never two cycles wide;
- a held tick produces no further pulses;
- the upper day bits and the unmapped addresses read zero;
- a seconds write reads back;
- each pulse coincides with matching seconds, minutes and hours fields or their wildcards.

Some behaviours can only be shown by the bench's scenarios:
- the choice between matching and missing for the day and month fields;
- wildcards other than 0xFF;
- the day value of zero;
- the ordering when a write lands on the tick edge;
- the absence of optional fields, checked on a second instance built without them.

// File: rtl/bcd_alarm_pkg.sv
// Shared constants and helpers for the BCD alarm comparator.
// Assumes 8-bit packed BCD fields and a fixed five-field register map.
package bcd_alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 5;
    localparam int ADDR_W     = 3;

    // Field index doubles as register address; ordering is fixed by the map.
    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DAY  = 3;
    localparam int IDX_MON  = 4;

    typedef enum logic [1:0] {
        KIND_TIME  = 2'd0,
        KIND_DAY   = 2'd1,
        KIND_MONTH = 2'd2
    } field_kind_e;

    // Comparison style used by a given field index.
    function automatic field_kind_e kind_of(input int idx);
        if (idx == IDX_DAY)      return KIND_DAY;
        else if (idx == IDX_MON) return KIND_MONTH;
        else                     return KIND_TIME;
    endfunction

    // Value each alarm byte takes at reset.
    function automatic logic [FIELD_W-1:0] reset_value(input int idx);
        return (idx == IDX_MON) ? 8'hFF : 8'h00;
    endfunction

    // Whether a field exists for the given build options.
    function automatic bit field_present(input int idx, input bit has_day, input bit has_mon);
        if (idx == IDX_DAY)      return has_day;
        else if (idx == IDX_MON) return has_day && has_mon;
        else                     return 1'b1;
    endfunction
endpackage

// File: rtl/bcd_alarm_field.sv
// Compares one alarm byte with one current-time byte.
// KIND_TIME and KIND_MONTH: wildcard when bits 7:6 are both set, else exact match.
// KIND_DAY: wildcard also when bits 5:0 are zero; only bits 5:0 are compared.
module bcd_alarm_field
    import bcd_alarm_pkg::*;
#(
    parameter field_kind_e KIND = KIND_TIME
) (
    input  logic [FIELD_W-1:0] alarm_byte,
    input  logic [FIELD_W-1:0] now_byte,
    output logic               hit
);
    logic wild;

    generate
        if (KIND == KIND_DAY) begin : g_day
            // Day: wildcard on top pair or zero value; compare the six value bits.
            always_comb begin
                wild = (alarm_byte[7] & alarm_byte[6]) | (alarm_byte[5:0] == 6'd0);
                hit  = wild | (now_byte == {2'b00, alarm_byte[5:0]});
            end
        end else begin : g_full
            // Time and month: wildcard on top pair; compare whole byte.
            always_comb begin
                wild = alarm_byte[7] & alarm_byte[6];
                hit  = wild | (now_byte == alarm_byte);
            end
        end
    endgenerate
endmodule

// File: rtl/bcd_alarm_regs.sv
// Alarm byte storage with write strobe and combinational readback.
// Absent optional fields read zero and ignore writes. Day readback masks bits 7:6.
module bcd_alarm_regs
    import bcd_alarm_pkg::*;
#(
    parameter bit HAS_DAY   = 1'b1,
    parameter bit HAS_MONTH = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [FIELD_W-1:0]                 wdata,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q,
    output logic [FIELD_W-1:0]                 rdata
);
    logic [FIELD_W-1:0] regs_q [NUM_FIELDS];

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            if (field_present(i, HAS_DAY, HAS_MONTH)) begin : g_on
                // Hold one alarm byte; load it on an addressed write.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs_q[i] <= reset_value(i);
                    else if (wr_en && (addr == ADDR_W'(i)))
                        regs_q[i] <= wdata;
                end
            end else begin : g_off
                assign regs_q[i] = '0;
            end
            assign alarm_q[i] = regs_q[i];
        end
    endgenerate

    // Select the addressed byte for readback; unmapped addresses give zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (addr == ADDR_W'(k))
                rdata = (k == IDX_DAY) ? {2'b00, regs_q[k][5:0]} : regs_q[k];
        end
    end
endmodule

// File: rtl/bcd_alarm_match.sv
// BCD alarm comparator top. It detects the rising edge of the new-second strobe,
// evaluates all field comparators, and registers a one-clock match pulse.
// Assumes 24-hour BCD time inputs that are stable around the tick edge.
module bcd_alarm_match
    import bcd_alarm_pkg::*;
#(
    parameter bit HAS_DAY   = 1'b1,
    parameter bit HAS_MONTH = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               tick,
    input  logic [7:0]         now_sec,
    input  logic [7:0]         now_min,
    input  logic [7:0]         now_hour,
    input  logic [7:0]         now_day,
    input  logic [7:0]         now_mon,
    output logic               alarm_hit
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_v;
    logic [NUM_FIELDS-1:0]              field_hit;
    logic                               tick_q;
    logic                               new_sec;
    logic                               hit_q;

    assign now_v = {now_mon, now_day, now_hour, now_min, now_sec};

    bcd_alarm_regs #(
        .HAS_DAY   (HAS_DAY),
        .HAS_MONTH (HAS_MONTH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .alarm_q (alarm_q),
        .rdata   (reg_rdata)
    );

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
            if (field_present(i, HAS_DAY, HAS_MONTH)) begin : g_on
                bcd_alarm_field #(
                    .KIND (kind_of(i))
                ) u_field (
                    .alarm_byte (alarm_q[i]),
                    .now_byte   (now_v[i]),
                    .hit        (field_hit[i])
                );
            end else begin : g_off
                assign field_hit[i] = 1'b1;
            end
        end
    endgenerate

    assign new_sec = tick & ~tick_q;

    // Remember the strobe level to find its first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick;
    end

    // Register the match pulse on the first cycle of each new second.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= new_sec & (&field_hit);
    end

    assign alarm_hit = hit_q;
endmodule

// File: rtl/bcd_alarm_match_chk.sv
// Property checker for the BCD alarm comparator, attached to every instance by bind.
// It observes ports plus the stored alarm bytes.
module bcd_alarm_match_chk
    import bcd_alarm_pkg::*;
(
    input logic                               clk,
    input logic                               rst_n,
    input logic                               tick,
    input logic                               alarm_hit,
    input logic                               reg_wr,
    input logic [2:0]                         reg_addr,
    input logic [7:0]                         reg_wdata,
    input logic [7:0]                         reg_rdata,
    input logic [7:0]                         now_sec,
    input logic [7:0]                         now_min,
    input logic [7:0]                         now_hour,
    input logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q
);
    // R4
    hit_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(tick));

    // R4
    hit_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !alarm_hit);

    // R8
    held_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && $past(tick, 2)) |-> !alarm_hit);

    // R3
    day_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd3) |-> (reg_rdata[7:6] == 2'b00));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= 3'd5) |-> (reg_rdata == 8'h00));

    // R2
    sec_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_wr) && ($past(reg_addr) == 3'd0) && (reg_addr == 3'd0))
        |-> (reg_rdata == $past(reg_wdata)));

    // R5
    time_fields_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(((alarm_q[0][7:6] == 2'b11) || (alarm_q[0] == now_sec)) &&
                            ((alarm_q[1][7:6] == 2'b11) || (alarm_q[1] == now_min)) &&
                            ((alarm_q[2][7:6] == 2'b11) || (alarm_q[2] == now_hour))));
endmodule

bind bcd_alarm_match bcd_alarm_match_chk u_chk (.*);

// File: tb/bcd_alarm_match_test.sv
// Directed bench: one task per scenario, each checking its own results.
module bcd_alarm_match_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00;
    logic [7:0] now_day = 8'h01, now_mon = 8'h01;
    logic [7:0] rdata, rdata_nd;
    logic       hit, hit_nd;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bcd_alarm_match uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_mon(now_mon), .alarm_hit(hit)
    );

    bcd_alarm_match #(.HAS_DAY(1'b0), .HAS_MONTH(1'b1)) uut_nd (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nd), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_mon(now_mon), .alarm_hit(hit_nd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_check(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(rdata == exp, req, rdata, exp);
    endtask

    task automatic set_now(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo);
        now_sec = s; now_min = m; now_hour = h; now_day = d; now_mon = mo;
    endtask

    task automatic set_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] d, input logic [7:0] mo);
        write_reg(3'd0, s); write_reg(3'd1, m); write_reg(3'd2, h);
        write_reg(3'd3, d); write_reg(3'd4, mo);
    endtask

    // One tick pulse; check the pulse cycle and the cycle after (R4).
    task automatic tick_check(input bit exp, input bit exp_nd, input string req);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(hit == exp, req, hit, exp);
        check(hit_nd == exp_nd, {req, " no-day"}, hit_nd, exp_nd);
        @(negedge clk);
        check(hit == 1'b0, "R4 width", hit, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(hit == 1'b0, "R1 hit", hit, 0);
        read_check(3'd0, 8'h00, "R1 sec");
        read_check(3'd1, 8'h00, "R1 min");
        read_check(3'd2, 8'h00, "R1 hour");
        read_check(3'd3, 8'h00, "R1 day");
        read_check(3'd4, 8'hFF, "R1 month");
    endtask

    task automatic t_regmap();
        set_alarm(8'h12, 8'h34, 8'h21, 8'hE5, 8'h11);
        read_check(3'd0, 8'h12, "R2 sec");
        read_check(3'd1, 8'h34, "R2 min");
        read_check(3'd2, 8'h21, "R2 hour");
        read_check(3'd3, 8'h25, "R3 day mask");
        read_check(3'd4, 8'h11, "R2 month");
        write_reg(3'd5, 8'h77);
        read_check(3'd5, 8'h00, "R2 unmapped");
        read_check(3'd7, 8'h00, "R2 unmapped 7");
        @(negedge clk);
        reg_addr = 3'd3;
        #1;
        check(rdata_nd == 8'h00, "R9 day absent", rdata_nd, 0);
        reg_addr = 3'd4;
        #1;
        check(rdata_nd == 8'h00, "R9 month absent", rdata_nd, 0);
    endtask

    task automatic t_exact();
        set_alarm(8'h56, 8'h34, 8'h12, 8'h15, 8'h07);
        set_now(8'h56, 8'h34, 8'h12, 8'h15, 8'h07);
        tick_check(1'b1, 1'b1, "R5 exact match");
        set_now(8'h57, 8'h34, 8'h12, 8'h15, 8'h07);
        tick_check(1'b0, 1'b0, "R5 sec mismatch");
        set_now(8'h56, 8'h34, 8'h13, 8'h15, 8'h07);
        tick_check(1'b0, 1'b0, "R5 hour mismatch");
        set_now(8'h56, 8'h34, 8'h12, 8'h16, 8'h07);
        tick_check(1'b0, 1'b1, "R6 day mismatch R9");
    endtask

    task automatic t_wild();
        set_alarm(8'hC0, 8'h34, 8'h12, 8'h00, 8'hFF);
        set_now(8'h07, 8'h34, 8'h12, 8'h09, 8'h03);
        tick_check(1'b1, 1'b1, "R5 C0 wildcard");
        write_reg(3'd0, 8'h80);
        set_now(8'h00, 8'h34, 8'h12, 8'h09, 8'h03);
        tick_check(1'b0, 1'b0, "R5 80 not wildcard");
        write_reg(3'd0, 8'hC0);
        write_reg(3'd2, 8'hFF);
        set_now(8'h00, 8'h34, 8'h05, 8'h09, 8'h03);
        tick_check(1'b1, 1'b1, "R5 hour wildcard");
    endtask

    task automatic t_day();
        set_alarm(8'hC0, 8'hC0, 8'hC0, 8'hC3, 8'hFF);
        set_now(8'h01, 8'h02, 8'h03, 8'h21, 8'h05);
        tick_check(1'b1, 1'b1, "R6 top-pair wildcard");
        write_reg(3'd3, 8'h15);
        set_now(8'h01, 8'h02, 8'h03, 8'h16, 8'h05);
        tick_check(1'b0, 1'b1, "R6 day compare R9");
        write_reg(3'd3, 8'h55);
        set_now(8'h01, 8'h02, 8'h03, 8'h15, 8'h05);
        tick_check(1'b1, 1'b1, "R6 low six bits");
        write_reg(3'd3, 8'h40);
        set_now(8'h01, 8'h02, 8'h03, 8'h30, 8'h05);
        tick_check(1'b1, 1'b1, "R6 zero wildcard");
    endtask

    task automatic t_month();
        set_alarm(8'hC0, 8'hC0, 8'hC0, 8'h00, 8'h07);
        set_now(8'h11, 8'h22, 8'h23, 8'h04, 8'h08);
        tick_check(1'b0, 1'b1, "R7 month mismatch R9");
        set_now(8'h11, 8'h22, 8'h23, 8'h04, 8'h07);
        tick_check(1'b1, 1'b1, "R7 month match");
        write_reg(3'd4, 8'hC0);
        set_now(8'h11, 8'h22, 8'h23, 8'h04, 8'h11);
        tick_check(1'b1, 1'b1, "R7 month wildcard");
    endtask

    task automatic t_hold();
        int pulses = 0;
        set_alarm(8'hC0, 8'hC0, 8'hC0, 8'h00, 8'hFF);
        @(negedge clk);
        tick = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (hit) pulses++;
        end
        tick = 1'b0;
        @(negedge clk);
        if (hit) pulses++;
        check(pulses == 1, "R8 held tick", pulses, 1);
    endtask

    task automatic t_same_edge();
        set_alarm(8'h10, 8'hC0, 8'hC0, 8'h00, 8'hFF);
        set_now(8'h20, 8'h00, 8'h00, 8'h01, 8'h01);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h20; tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick = 1'b0;
        check(hit == 1'b0, "R10 old value used", hit, 0);
        tick_check(1'b1, 1'b1, "R10 new value next tick");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_exact();
        t_wild();
        t_day();
        t_month();
        t_hold();
        t_same_edge();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule